// File: doc/BRIEF.md
# Three-Level Nested Priority Interrupt Controller

This block collects interrupt requests from a set of devices and presents one of them at a time to a processor. Each device is placed by a configuration field on one of three priority levels: level 1 is the most urgent, level 3 the least. A request is latched as soon as the device line is seen and stays latched until the processor accepts that device. A global enable and a per-level mask decide which latched requests take part in arbitration.

Among the enabled pending levels, the most urgent one wins. It is presented only if it outranks every routine already in service. Once a level is chosen, the device is found by walking the device indices in order, one index per clock. The lowest index on that level is therefore found first, and devices with higher indices take longer to identify. An accept pulse from the processor records the level as in service and clears that device's latched request. An end-of-service pulse retires the most urgent level in service, so nested routines unwind in the correct order. Requests at the same level as a routine in service, or at a less urgent level, are held until it returns.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset `cpuIrq` is 0, `irqLevel` is 0 and `activeLevel` is 0. `irqLevel` reads 0 whenever `cpuIrq` is low.
- R2: A rising request is latched on the first clock edge that samples it. It is still serviced if the device line drops on the next cycle.
- R3: While `globalEn` is 0, or while the mask bit of a level is 1 (`levelMask` bit 0 = level 1, bit 1 = level 2, bit 2 = level 3), latched requests of that level are not presented. They stay pending and are presented once the gate opens.
- R4: When several levels have enabled pending requests, the level with the smallest code (1 before 2 before 3) is presented first. `irqLevel` carries that code.
- R5: Within the chosen level, the pending device with the lowest index is presented on `irqDev`. With the block idle and nothing in service, `cpuIrq` rises on the (k+3)-th rising edge, counting the edge that first samples the request of device k.
- R6: `ack` while `cpuIrq` is high takes effect on the next edge. `cpuIrq` falls, `activeLevel` becomes the presented level, and that device's latched request is cleared, so it is not presented again.
- R7: While a level is in service, only requests with a strictly smaller level code are presented. Requests with an equal or larger code wait until end of service uncovers a less urgent level.
- R8: `eoi` removes the most urgent level in service, and `activeLevel` returns to the level that was interrupted, or to 0. `eoi` with nothing in service has no effect.
- R9: A device whose 2-bit field in `levelCfg` (bits 2i+1:2i for device i) is 0 is not connected and never causes `cpuIrq`.
- R10: `ack` while `cpuIrq` is low leaves `activeLevel` and the pending requests unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| devReq | input | NUM_DEV | Request lines, one per device |
| levelCfg | input | 2*NUM_DEV | Level code per device: 1, 2, 3 or 0 for none |
| globalEn | input | 1 | Master enable for presenting requests |
| levelMask | input | 3 | Per-level mask, bit 0 = level 1 |
| ack | input | 1 | Processor accepts the presented interrupt |
| eoi | input | 1 | End of the most urgent routine in service |
| cpuIrq | output | 1 | Interrupt request to the processor |
| irqLevel | output | 2 | Level code of the presented interrupt, 0 when none |
| irqDev | output | $clog2(NUM_DEV) | Index of the presented device |
| activeLevel | output | 2 | Most urgent level in service, 0 when none |

## Verification
A corrupted pending latch shows at the ports as a device that is presented a second time after its accept, or as a device that is never presented at all. The next arbitration round reveals it within index+3 cycles. A wrong scan index or step count shifts the edge on which `cpuIrq` rises, or names the wrong `irqDev`. The latency sweep over every device and level catches this on the exact cycle. A damaged in-service vector changes `activeLevel` right after the `ack` or `eoi` that touched it. Nested preempt-and-return sequences then show it as a request that is wrongly held or wrongly allowed to preempt.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SCAN = 2'd1,
    PH_SHOW = 2'd2
  } phase_t;

  typedef struct packed {
    logic startScan;
    logic stepScan;
    logic grab;
    logic accept;
    logic pop;
  } strobe_t;

  localparam int unsigned NUM_LEVELS = 3;
endpackage

// File: rtl/nest_irq_dp.sv
module nest_irq_dp
  import nest_irq_pkg::*;
#(
  parameter int unsigned NUM_DEV = 8,
  localparam int unsigned IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_DEV-1:0]   devReq,
  input  logic [2*NUM_DEV-1:0] levelCfg,
  input  logic                 globalEn,
  input  logic [2:0]           levelMask,
  input  strobe_t              stb,
  output logic                 preempt,
  output logic                 scanHit,
  output logic                 scanLast,
  output logic [1:0]           curLevel,
  output logic [IDX_W-1:0]     curDev,
  output logic [1:0]           activeLevel
);
  logic [NUM_DEV-1:0] pend;
  logic [NUM_DEV-1:0] clrMask;
  logic [1:0]         levelOf [NUM_DEV];
  logic [NUM_DEV-1:0] onLevel [NUM_LEVELS];
  logic [NUM_LEVELS-1:0] levelLive;
  logic [NUM_LEVELS-1:0] inSvc;
  logic [1:0]         bestLevel;
  logic [IDX_W-1:0]   scanIdx;

  // pending latch per device
  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    assign levelOf[i] = levelCfg[2*i +: 2];
    assign clrMask[i] = stb.accept && (curDev == IDX_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           pend[i] <= 1'b0;
      else if (clrMask[i]) pend[i] <= 1'b0;
      else if (devReq[i])  pend[i] <= 1'b1;
    end
  end

  // per-level membership and gating
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_mem
      assign onLevel[l][i] = (levelOf[i] == 2'(l + 1));
    end
    assign levelLive[l] = globalEn && !levelMask[l] && |(pend & onLevel[l]);
  end

  always_comb begin
    bestLevel = 2'd0;
    if (levelLive[0])      bestLevel = 2'd1;
    else if (levelLive[1]) bestLevel = 2'd2;
    else if (levelLive[2]) bestLevel = 2'd3;
  end

  always_comb begin
    activeLevel = 2'd0;
    if (inSvc[0])      activeLevel = 2'd1;
    else if (inSvc[1]) activeLevel = 2'd2;
    else if (inSvc[2]) activeLevel = 2'd3;
  end

  assign preempt  = (bestLevel != 2'd0) &&
                    ((activeLevel == 2'd0) || (bestLevel < activeLevel));
  assign scanHit  = pend[scanIdx] && (levelOf[scanIdx] == curLevel);
  assign scanLast = (scanIdx == IDX_W'(NUM_DEV - 1));

  // scan cursor and captured device
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curLevel <= 2'd0;
      scanIdx  <= '0;
      curDev   <= '0;
    end else begin
      if (stb.startScan) begin
        curLevel <= bestLevel;
        scanIdx  <= '0;
      end else if (stb.stepScan) begin
        scanIdx <= scanIdx + 1'b1;
      end
      if (stb.grab) curDev <= scanIdx;
    end
  end

  // in-service vector: bit 0 is level 1; pop clears the most urgent bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSvc <= '0;
    end else begin
      logic [NUM_LEVELS-1:0] nxt;
      nxt = inSvc;
      if (stb.pop) nxt = nxt & (nxt - 1'b1);
      if (stb.accept && curLevel != 2'd0) nxt[curLevel - 2'd1] = 1'b1;
      inSvc <= nxt;
    end
  end
endmodule

// File: rtl/nest_irq_fsm.sv
module nest_irq_fsm
  import nest_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    preempt,
  input  logic    scanHit,
  input  logic    scanLast,
  input  logic    ack,
  input  logic    eoi,
  output strobe_t stb,
  output logic    showing
);
  phase_t phase, phaseNxt;

  always_comb begin
    stb      = '0;
    phaseNxt = phase;
    stb.pop  = eoi;
    unique case (phase)
      PH_IDLE: if (preempt) begin
        stb.startScan = 1'b1;
        phaseNxt      = PH_SCAN;
      end
      PH_SCAN: if (scanHit) begin
        stb.grab = 1'b1;
        phaseNxt = PH_SHOW;
      end else if (scanLast) begin
        phaseNxt = PH_IDLE;
      end else begin
        stb.stepScan = 1'b1;
      end
      PH_SHOW: if (ack) begin
        stb.accept = 1'b1;
        phaseNxt   = PH_IDLE;
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  assign showing = (phase == PH_SHOW);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nest_irq_pkg::*;
#(
  parameter int unsigned NUM_DEV = 8,
  localparam int unsigned IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_DEV-1:0]   devReq,
  input  logic [2*NUM_DEV-1:0] levelCfg,
  input  logic                 globalEn,
  input  logic [2:0]           levelMask,
  input  logic                 ack,
  input  logic                 eoi,
  output logic                 cpuIrq,
  output logic [1:0]           irqLevel,
  output logic [IDX_W-1:0]     irqDev,
  output logic [1:0]           activeLevel
);
  strobe_t          stb;
  logic             preempt, scanHit, scanLast, showing;
  logic [1:0]       curLevel;
  logic [IDX_W-1:0] curDev;

  nest_irq_dp #(.NUM_DEV(NUM_DEV)) u_dp (
    .clk(clk), .rstN(rstN), .devReq(devReq), .levelCfg(levelCfg),
    .globalEn(globalEn), .levelMask(levelMask), .stb(stb),
    .preempt(preempt), .scanHit(scanHit), .scanLast(scanLast),
    .curLevel(curLevel), .curDev(curDev), .activeLevel(activeLevel)
  );

  nest_irq_fsm u_fsm (
    .clk(clk), .rstN(rstN), .preempt(preempt), .scanHit(scanHit),
    .scanLast(scanLast), .ack(ack), .eoi(eoi), .stb(stb), .showing(showing)
  );

  assign cpuIrq   = showing;
  assign irqLevel = showing ? curLevel : 2'd0;
  assign irqDev   = showing ? curDev : '0;
endmodule

// File: rtl/nest_irq_chk.sv
module nest_irq_chk #(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             ack,
  input logic             eoi,
  input logic             cpuIrq,
  input logic [1:0]       irqLevel,
  input logic [IDX_W-1:0] irqDev,
  input logic [1:0]       activeLevel
);
  // R1
  quiet_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuIrq |-> irqLevel == 2'd0);

  // R7
  outranks_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> (irqLevel != 2'd0) &&
               ((activeLevel == 2'd0) || (irqLevel < activeLevel)));

  // R6
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIrq && !ack) |=> cpuIrq && $stable(irqLevel) && $stable(irqDev));

  // R6
  ack_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIrq && ack) |=> !cpuIrq && activeLevel == $past(irqLevel));

  // R8
  eoi_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoi && !(cpuIrq && ack) && activeLevel != 2'd0) |=>
      (activeLevel == 2'd0) || (activeLevel > $past(activeLevel)));

  // R10
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuIrq && ack && !eoi) |=> activeLevel == $past(activeLevel));
endmodule

bind nest_irq_ctrl nest_irq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .ack(ack), .eoi(eoi), .cpuIrq(cpuIrq),
  .irqLevel(irqLevel), .irqDev(irqDev), .activeLevel(activeLevel)
);

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
  localparam int N = 6;
  localparam int IW = $clog2(N);

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [N-1:0]   devReq = '0;
  logic [2*N-1:0] levelCfg = '0;
  logic           globalEn = 1'b1;
  logic [2:0]     levelMask = '0;
  logic           ack = 1'b0;
  logic           eoi = 1'b0;
  logic           cpuIrq;
  logic [1:0]     irqLevel;
  logic [IW-1:0]  irqDev;
  logic [1:0]     activeLevel;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nest_irq_ctrl #(.NUM_DEV(N)) u_dut (
    .clk(clk), .rstN(rstN), .devReq(devReq), .levelCfg(levelCfg),
    .globalEn(globalEn), .levelMask(levelMask), .ack(ack), .eoi(eoi),
    .cpuIrq(cpuIrq), .irqLevel(irqLevel), .irqDev(irqDev),
    .activeLevel(activeLevel)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setLvl(input int dev, input int lvl);
    levelCfg[2*dev +: 2] = 2'(lvl);
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    while (!cpuIrq && n < 40) begin
      tick();
      n++;
    end
  endtask

  task automatic doAck();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  task automatic doEoi();
    eoi = 1'b1;
    tick();
    eoi = 1'b0;
  endtask

  task automatic pulseReq(input int dev);
    devReq[dev] = 1'b1;
    tick();
    devReq[dev] = 1'b0;
  endtask

  task automatic quietFor(input int cyc, input string req);
    bit seen;
    seen = 1'b0;
    for (int c = 0; c < cyc; c++) begin
      tick();
      if (cpuIrq) seen = 1'b1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=1 expected=0");
      finishRun();
    end
  end

  initial begin
    int n;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cpuIrq == 1'b0, "R1 cpuIrq", int'(cpuIrq), 0);
    chk(irqLevel == 2'd0, "R1 irqLevel", int'(irqLevel), 0);
    chk(activeLevel == 2'd0, "R1 activeLevel", int'(activeLevel), 0);
    rstN = 1'b1;
    tick();

    // R5 / R2 / R6 / R8 sweep over every device and level
    for (int lv = 1; lv <= 3; lv++) begin
      for (int k = 0; k < N; k++) begin
        levelCfg = '0;
        setLvl(k, lv);
        devReq[k] = 1'b1;
        tick();
        devReq[k] = 1'b0;
        n = 1;
        while (!cpuIrq && n < 40) begin
          tick();
          n++;
        end
        chk(n == k + 3, "R5 latency R2", n, k + 3);
        chk(irqLevel == 2'(lv), "R4 level code", int'(irqLevel), lv);
        chk(irqDev == IW'(k), "R5 device index", int'(irqDev), k);
        doAck();
        chk(!cpuIrq && activeLevel == 2'(lv), "R6 ack push", int'(activeLevel), lv);
        doEoi();
        chk(activeLevel == 2'd0, "R8 return to idle", int'(activeLevel), 0);
        quietFor(N + 4, "R6 request cleared");
      end
    end

    // R4 three levels at once, then R7 hold and R8 unwind
    levelCfg = '0;
    setLvl(1, 3); setLvl(2, 2); setLvl(4, 1);
    devReq = 6'b010110;
    tick();
    devReq = '0;
    waitIrq(n);
    chk(irqLevel == 2'd1 && irqDev == IW'(4), "R4 most urgent first", int'(irqDev), 4);
    doAck();
    quietFor(3 * N, "R7 lower held under level 1");
    doEoi();
    waitIrq(n);
    chk(irqLevel == 2'd2 && irqDev == IW'(2), "R4 level 2 next", int'(irqDev), 2);
    doAck();
    doEoi();
    waitIrq(n);
    chk(irqLevel == 2'd3 && irqDev == IW'(1), "R4 level 3 last", int'(irqDev), 1);
    doAck();
    doEoi();

    // R5 same level, lowest index wins
    levelCfg = '0;
    setLvl(2, 3); setLvl(4, 3);
    devReq = 6'b010100;
    tick();
    devReq = '0;
    waitIrq(n);
    chk(irqDev == IW'(2), "R5 lowest index wins", int'(irqDev), 2);
    doAck(); doEoi();
    waitIrq(n);
    chk(irqDev == IW'(4), "R5 second device follows", int'(irqDev), 4);
    doAck(); doEoi();

    // R7 preemption and nesting
    levelCfg = '0;
    setLvl(0, 3); setLvl(5, 2); setLvl(3, 2);
    pulseReq(0);
    waitIrq(n);
    doAck();
    chk(activeLevel == 2'd3, "R7 level 3 in service", int'(activeLevel), 3);
    pulseReq(5);
    waitIrq(n);
    chk(cpuIrq && irqLevel == 2'd2 && irqDev == IW'(5), "R7 level 2 preempts", int'(irqDev), 5);
    doAck();
    chk(activeLevel == 2'd2, "R7 nested level 2", int'(activeLevel), 2);
    // R10 ack while idle has no effect
    doAck();
    chk(activeLevel == 2'd2, "R10 stray ack", int'(activeLevel), 2);
    pulseReq(3);
    quietFor(3 * N, "R7 equal level held");
    doEoi();
    chk(activeLevel == 2'd3, "R8 back to interrupted level", int'(activeLevel), 3);
    waitIrq(n);
    chk(cpuIrq && irqDev == IW'(3), "R7 held request after return", int'(irqDev), 3);
    doAck();
    doEoi();
    chk(activeLevel == 2'd3, "R8 unwind to 3", int'(activeLevel), 3);
    doEoi();
    chk(activeLevel == 2'd0, "R8 unwind to idle", int'(activeLevel), 0);
    doEoi();
    chk(activeLevel == 2'd0, "R8 eoi when empty", int'(activeLevel), 0);
    quietFor(2 * N, "R8 nothing left");

    // R3 global enable gating
    levelCfg = '0;
    setLvl(1, 2);
    globalEn = 1'b0;
    pulseReq(1);
    quietFor(3 * N, "R3 global disable");
    globalEn = 1'b1;
    waitIrq(n);
    chk(cpuIrq && irqDev == IW'(1), "R3 released after enable", int'(irqDev), 1);
    doAck(); doEoi();

    // R3 level mask gating
    levelCfg = '0;
    setLvl(3, 3); setLvl(5, 1);
    levelMask = 3'b100;
    pulseReq(3);
    quietFor(3 * N, "R3 level 3 masked");
    pulseReq(5);
    waitIrq(n);
    chk(cpuIrq && irqLevel == 2'd1, "R3 unmasked level passes", int'(irqLevel), 1);
    doAck(); doEoi();
    quietFor(2 * N, "R3 masked stays pending");
    levelMask = 3'b000;
    waitIrq(n);
    chk(cpuIrq && irqDev == IW'(3) && irqLevel == 2'd3, "R3 released after unmask", int'(irqDev), 3);
    doAck(); doEoi();

    // R9 unassigned device
    levelCfg = '0;
    setLvl(0, 1);
    pulseReq(2);
    quietFor(3 * N, "R9 unassigned ignored");
    chk(activeLevel == 2'd0, "R9 nothing in service", int'(activeLevel), 0);

    finishRun();
  end
endmodule